// File: doc/BRIEF.md
# Timer-Coprocessor ALU Execute Unit

This block is the arithmetic and logic execute stage of a small timer coprocessor. Each clock cycle it takes one 32-bit control word and decodes it into an operation, two source selectors, a register destination and a remote destination. It then computes one result. The result is committed at the next rising edge to a local register set. That set holds two 25-bit registers (A, B), three 32-bit registers (R, S, T) and a carry flag.

Sources come in several widths, and every source is brought to 32 bits before the operation. A 25-bit register is shifted up by eight bit places. The remote 9-bit field is zero-extended. The other sources are already 32 bits wide. The result is cut down separately for each destination written.

A remote-memory destination is driven combinationally in the same cycle as the control word. Storing that value belongs to the surrounding memory. The shift/rotate fields of the control word are routed to a post-operation hook that currently passes the result through unchanged.

Top module: `tca_exec`

## Requirements
- R1: While `rst` is high at a rising edge, A, B, R, S, T and the carry flag all become zero. With an all-zero control word, `rmt_we` stays low.
- R2: Control bits [25:23] select the operation. The codes are 001 add, 010 and, 011 add with carry, 100 or, 101 subtract, 110 subtract with borrow, 111 xor. All arithmetic is 32-bit and wraps modulo 2^32.
- R3: Operation code 000 writes nothing. No register and no carry flag changes at the next edge, and `rmt_we` stays low.
- R4: For add and add-with-carry, the carry flag takes the carry out of bit 31. Add-with-carry also adds the old flag. For subtract and subtract-with-borrow, the flag is set exactly when a borrow occurs, and subtract-with-borrow also subtracts the old flag. And, or and xor leave the flag unchanged.
- R5: The first source is chosen by bits [22:19]. The codes are 0000 zero, 0001 `imm_data`, 0010 A, 0011 B, 0100 R, 0101 S, 0110 T, 0111 all ones, 1000 `rmt_rd_data`, and 1001 `rmt_rd_data[8:0]` zero-extended. Codes 1010 to 1111 give zero.
- R6: The second source is chosen by bits [18:16]. It uses codes 000 to 111 with the same meaning as the first eight first-source codes.
- R7: A or B used as a source reads as `{reg[23:0], 8'h00}`, so the top register bit is dropped.
- R8: The register destination is chosen by bit 7 together with bits [2:1]. With bit 7 = 0, code 00 is A, 01 is B and 10 is T. With bit 7 = 1, code 00 is R and 01 is S. Every other combination writes no register, although the carry flag is still updated as R4 states.
- R9: A written register A or B receives `{1'b0, result[31:8]}`. A written register R, S or T receives the full 32-bit result.
- R10: Bits [4:3] select the remote destination. Code 01 gives `rmt_we`=1 and `rmt_field`=0 with `rmt_wr_data` = result. Code 10 gives `rmt_we`=1 and `rmt_field`=1 with `rmt_wr_data` = `{23'b0, result[8:0]}`. Codes 00 and 11 give `rmt_we`=0. These outputs are valid in the same cycle as the control word.
- R11: One instruction may write a register destination and a remote destination together. Each destination gets the same result, truncated to its own width.
- R12: The shift-mode bits [15:13] and shift-count bits [12:8] have no effect on any result, register or remote output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_word | input | 32 | Control word for the current cycle |
| imm_data | input | 32 | Instruction data field (immediate source) |
| rmt_rd_data | input | 32 | Remote memory read word |
| carry_q | output | 1 | Carry/borrow flag |
| reg_a | output | 25 | Register A |
| reg_b | output | 25 | Register B |
| reg_r | output | 32 | Register R |
| reg_s | output | 32 | Register S |
| reg_t | output | 32 | Register T |
| rmt_we | output | 1 | Remote write enable |
| rmt_field | output | 1 | Remote write targets the 9-bit field |
| rmt_wr_data | output | 32 | Remote write data |

## Verification
Several corner cases get directed tests alongside the random control words:
- An all-ones plus all-ones add and a zero-minus-nonzero subtract check the carry and borrow flag. A design with a wrong carry polarity or no carry-in would leave the flag or the low result bit off by one.
- Round trips through A check the eight-bit alignment. Reading A back as a source must return `{A[23:0],8'h00}`, so a missing shift or a kept top bit shows up at once.
- The unlisted destination codes and the all-zero opcode must write nothing.
- A field-mode remote write must clear bits above bit 8.
- A shift field full of ones must not change the outcome of the same instruction.

// File: rtl/tca_pkg.sv
`timescale 1ns/1ps
package tca_pkg;

    localparam int CTL_W = 32;

    // control word field positions
    localparam int OP_HI  = 25;
    localparam int OP_LO  = 23;
    localparam int S1_HI  = 22;
    localparam int S1_LO  = 19;
    localparam int S2_HI  = 18;
    localparam int S2_LO  = 16;
    localparam int SM_HI  = 15;
    localparam int SM_LO  = 13;
    localparam int SC_HI  = 12;
    localparam int SC_LO  = 8;
    localparam int DBANK  = 7;
    localparam int RD_HI  = 4;
    localparam int RD_LO  = 3;
    localparam int DSL_HI = 2;
    localparam int DSL_LO = 1;

    typedef enum logic [2:0] {
        OP_NOP = 3'b000,
        OP_ADD = 3'b001,
        OP_AND = 3'b010,
        OP_ADC = 3'b011,
        OP_OR  = 3'b100,
        OP_SUB = 3'b101,
        OP_SBB = 3'b110,
        OP_XOR = 3'b111
    } alu_op_e;

    localparam logic [3:0] SRC_ZERO   = 4'd0;
    localparam logic [3:0] SRC_IMM    = 4'd1;
    localparam logic [3:0] SRC_A      = 4'd2;
    localparam logic [3:0] SRC_B      = 4'd3;
    localparam logic [3:0] SRC_R      = 4'd4;
    localparam logic [3:0] SRC_S      = 4'd5;
    localparam logic [3:0] SRC_T      = 4'd6;
    localparam logic [3:0] SRC_ONES   = 4'd7;
    localparam logic [3:0] SRC_RWORD  = 4'd8;
    localparam logic [3:0] SRC_RFIELD = 4'd9;

    typedef enum logic [2:0] {
        DST_NONE,
        DST_A,
        DST_B,
        DST_R,
        DST_S,
        DST_T
    } dst_e;

    typedef enum logic [1:0] {
        RDST_NONE  = 2'b00,
        RDST_WORD  = 2'b01,
        RDST_FIELD = 2'b10,
        RDST_RSVD  = 2'b11
    } rdst_e;

    typedef struct packed {
        alu_op_e    op;
        logic [3:0] src1;
        logic [2:0] src2;
        dst_e       dst;
        rdst_e      rdst;
        logic [2:0] smode;
        logic [4:0] scount;
    } ctl_t;

    function automatic logic op_sets_carry(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) || (op == OP_SBB);
    endfunction

    function automatic logic rdst_writes(input rdst_e r);
        return (r == RDST_WORD) || (r == RDST_FIELD);
    endfunction

endpackage

// File: rtl/tca_decode.sv
`timescale 1ns/1ps
module tca_decode
    import tca_pkg::*;
(
    input  logic [CTL_W-1:0] ctl_word,
    output ctl_t             dec
);

    logic unused_ctl_bits;
    assign unused_ctl_bits = ^{ctl_word[CTL_W-1:OP_HI+1], ctl_word[DBANK-1:RD_HI+1],
                               ctl_word[DSL_LO-1:0]};

    always_comb begin
        dec.op     = alu_op_e'(ctl_word[OP_HI:OP_LO]);
        dec.src1   = ctl_word[S1_HI:S1_LO];
        dec.src2   = ctl_word[S2_HI:S2_LO];
        dec.rdst   = rdst_e'(ctl_word[RD_HI:RD_LO]);
        dec.smode  = ctl_word[SM_HI:SM_LO];
        dec.scount = ctl_word[SC_HI:SC_LO];
        // R8: bank bit with two select bits; unlisted codes select nothing
        case ({ctl_word[DBANK], ctl_word[DSL_HI:DSL_LO]})
            3'b000:  dec.dst = DST_A;
            3'b001:  dec.dst = DST_B;
            3'b010:  dec.dst = DST_T;
            3'b100:  dec.dst = DST_R;
            3'b101:  dec.dst = DST_S;
            default: dec.dst = DST_NONE;
        endcase
    end

endmodule

// File: rtl/tca_src_mux.sv
`timescale 1ns/1ps
module tca_src_mux
    import tca_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NARROW_W  = 25,
    parameter int PAD_W     = 8,
    parameter int FIELD_W   = 9,
    parameter bit REMOTE_OK = 1'b1
) (
    input  logic [3:0]          sel,
    input  logic [NARROW_W-1:0] reg_a,
    input  logic [NARROW_W-1:0] reg_b,
    input  logic [DATA_W-1:0]   reg_r,
    input  logic [DATA_W-1:0]   reg_s,
    input  logic [DATA_W-1:0]   reg_t,
    input  logic [DATA_W-1:0]   imm,
    input  logic [DATA_W-1:0]   rword,
    output logic [DATA_W-1:0]   val
);

    localparam int KEEP_W = DATA_W - PAD_W;

    logic [DATA_W-1:0] rem_word;
    logic [DATA_W-1:0] rem_field;

    // R7: narrow registers are aligned upward; their top bit falls off
    function automatic logic [DATA_W-1:0] align_up(input logic [NARROW_W-1:0] v);
        return {v[KEEP_W-1:0], {PAD_W{1'b0}}};
    endfunction

    logic unused_narrow_hi;
    assign unused_narrow_hi = ^{reg_a[NARROW_W-1:KEEP_W], reg_b[NARROW_W-1:KEEP_W]};

    generate
        if (REMOTE_OK) begin : g_remote
            assign rem_word  = rword;
            assign rem_field = {{(DATA_W-FIELD_W){1'b0}}, rword[FIELD_W-1:0]};
        end else begin : g_local_only
            logic unused_rword;
            assign unused_rword = ^rword;
            assign rem_word  = '0;
            assign rem_field = '0;
        end
    endgenerate

    always_comb begin
        case (sel)
            SRC_ZERO:   val = '0;
            SRC_IMM:    val = imm;
            SRC_A:      val = align_up(reg_a);
            SRC_B:      val = align_up(reg_b);
            SRC_R:      val = reg_r;
            SRC_S:      val = reg_s;
            SRC_T:      val = reg_t;
            SRC_ONES:   val = '1;
            SRC_RWORD:  val = rem_word;
            SRC_RFIELD: val = rem_field;
            default:    val = '0;
        endcase
    end

endmodule

// File: rtl/tca_alu.sv
`timescale 1ns/1ps
module tca_alu
    import tca_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);

    logic [DATA_W:0] ext_l;
    logic [DATA_W:0] ext_r;
    logic [DATA_W:0] ext_c;
    logic [DATA_W:0] wide;

    assign ext_l = {1'b0, lhs};
    assign ext_r = {1'b0, rhs};
    assign ext_c = {{DATA_W{1'b0}}, cin};

    // bit DATA_W of the wide value is carry out for sums, borrow for differences
    always_comb begin
        case (op)
            OP_ADD:  wide = ext_l + ext_r;
            OP_ADC:  wide = ext_l + ext_r + ext_c;
            OP_SUB:  wide = ext_l - ext_r;
            OP_SBB:  wide = ext_l - ext_r - ext_c;
            OP_AND:  wide = {1'b0, lhs & rhs};
            OP_OR:   wide = {1'b0, lhs | rhs};
            OP_XOR:  wide = {1'b0, lhs ^ rhs};
            default: wide = '0;
        endcase
    end

    assign res  = wide[DATA_W-1:0];
    assign cout = wide[DATA_W];

endmodule

// File: rtl/tca_shift_hook.sv
`timescale 1ns/1ps
module tca_shift_hook #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    input  logic [2:0]        mode,
    input  logic [4:0]        count,
    output logic [DATA_W-1:0] dout
);

    // R12: the hook is a pass-through; mode and count reach it but change nothing
    logic unused_shift_ctl;
    assign unused_shift_ctl = ^{mode, count};
    assign dout = din;

endmodule

// File: rtl/tca_exec.sv
`timescale 1ns/1ps
module tca_exec
    import tca_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 25,
    parameter int PAD_W    = 8,
    parameter int FIELD_W  = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CTL_W-1:0]    ctl_word,
    input  logic [DATA_W-1:0]   imm_data,
    input  logic [DATA_W-1:0]   rmt_rd_data,
    output logic                carry_q,
    output logic [NARROW_W-1:0] reg_a,
    output logic [NARROW_W-1:0] reg_b,
    output logic [DATA_W-1:0]   reg_r,
    output logic [DATA_W-1:0]   reg_s,
    output logic [DATA_W-1:0]   reg_t,
    output logic                rmt_we,
    output logic                rmt_field,
    output logic [DATA_W-1:0]   rmt_wr_data
);

    localparam int KEEP_W = DATA_W - PAD_W;
    localparam int EXT_W  = NARROW_W - KEEP_W;

    ctl_t              dec;
    logic [DATA_W-1:0] opnd1;
    logic [DATA_W-1:0] opnd2;
    logic [DATA_W-1:0] alu_res;
    logic [DATA_W-1:0] fin_res;
    logic              alu_cout;
    logic              commit;

    tca_decode u_dec (
        .ctl_word (ctl_word),
        .dec      (dec)
    );

    tca_src_mux #(
        .DATA_W    (DATA_W),
        .NARROW_W  (NARROW_W),
        .PAD_W     (PAD_W),
        .FIELD_W   (FIELD_W),
        .REMOTE_OK (1'b1)
    ) u_src1 (
        .sel   (dec.src1),
        .reg_a (reg_a),
        .reg_b (reg_b),
        .reg_r (reg_r),
        .reg_s (reg_s),
        .reg_t (reg_t),
        .imm   (imm_data),
        .rword (rmt_rd_data),
        .val   (opnd1)
    );

    tca_src_mux #(
        .DATA_W    (DATA_W),
        .NARROW_W  (NARROW_W),
        .PAD_W     (PAD_W),
        .FIELD_W   (FIELD_W),
        .REMOTE_OK (1'b0)
    ) u_src2 (
        .sel   ({1'b0, dec.src2}),
        .reg_a (reg_a),
        .reg_b (reg_b),
        .reg_r (reg_r),
        .reg_s (reg_s),
        .reg_t (reg_t),
        .imm   (imm_data),
        .rword (rmt_rd_data),
        .val   (opnd2)
    );

    tca_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op   (dec.op),
        .lhs  (opnd1),
        .rhs  (opnd2),
        .cin  (carry_q),
        .res  (alu_res),
        .cout (alu_cout)
    );

    tca_shift_hook #(
        .DATA_W (DATA_W)
    ) u_shift (
        .din   (alu_res),
        .mode  (dec.smode),
        .count (dec.scount),
        .dout  (fin_res)
    );

    assign commit = (dec.op != OP_NOP);

    // R9: narrow destinations take the upper result bits, zero on top
    function automatic logic [NARROW_W-1:0] trim_narrow(input logic [DATA_W-1:0] v);
        return {{EXT_W{1'b0}}, v[DATA_W-1:PAD_W]};
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= 1'b0;
            reg_a   <= '0;
            reg_b   <= '0;
            reg_r   <= '0;
            reg_s   <= '0;
            reg_t   <= '0;
        end else if (commit) begin
            if (op_sets_carry(dec.op)) begin
                carry_q <= alu_cout;
            end
            case (dec.dst)
                DST_A:   reg_a <= trim_narrow(fin_res);
                DST_B:   reg_b <= trim_narrow(fin_res);
                DST_R:   reg_r <= fin_res;
                DST_S:   reg_s <= fin_res;
                DST_T:   reg_t <= fin_res;
                default: ;
            endcase
        end
    end

    // R10, R11: remote destination is driven in the cycle of the control word
    always_comb begin
        rmt_we    = commit && rdst_writes(dec.rdst);
        rmt_field = commit && (dec.rdst == RDST_FIELD);
        if (dec.rdst == RDST_FIELD) begin
            rmt_wr_data = {{(DATA_W-FIELD_W){1'b0}}, fin_res[FIELD_W-1:0]};
        end else begin
            rmt_wr_data = fin_res;
        end
    end

endmodule

// File: rtl/tca_exec_chk.sv
`timescale 1ns/1ps
module tca_exec_chk #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 25,
    parameter int FIELD_W  = 9
) (
    input logic                clk,
    input logic                rst,
    input logic [31:0]         ctl_word,
    input logic [DATA_W-1:0]   imm_data,
    input logic                carry_q,
    input logic [NARROW_W-1:0] reg_a,
    input logic [NARROW_W-1:0] reg_b,
    input logic [DATA_W-1:0]   reg_r,
    input logic [DATA_W-1:0]   reg_s,
    input logic [DATA_W-1:0]   reg_t,
    input logic                rmt_we,
    input logic                rmt_field,
    input logic [DATA_W-1:0]   rmt_wr_data
);

    logic [2:0] c_op;
    logic [3:0] c_s1;
    logic [2:0] c_s2;
    logic [2:0] c_dst;
    logic [1:0] c_rd;

    assign c_op  = ctl_word[25:23];
    assign c_s1  = ctl_word[22:19];
    assign c_s2  = ctl_word[18:16];
    assign c_dst = {ctl_word[7], ctl_word[2:1]};
    assign c_rd  = ctl_word[4:3];

    logic unused_chk_bits;
    assign unused_chk_bits = ^{ctl_word[31:26], ctl_word[15:8], ctl_word[6:5], ctl_word[0]};

    AST_NOP_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
        (c_op == 3'b000) |=> ($stable(reg_a) && $stable(reg_b) && $stable(reg_r) &&
                              $stable(reg_s) && $stable(reg_t) && $stable(carry_q))); // R3

    AST_NOP_NO_REMOTE: assert property (@(posedge clk) disable iff (rst)
        (c_op == 3'b000) |-> !rmt_we); // R3

    AST_LOGIC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
        (c_op == 3'b010 || c_op == 3'b100 || c_op == 3'b111) |=> $stable(carry_q)); // R4

    AST_FIELD_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rmt_we && rmt_field) |-> (rmt_wr_data[DATA_W-1:FIELD_W] == '0)); // R10

    AST_XOR_SELF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (c_op == 3'b111 && c_s1 == 4'b0100 && c_s2 == 3'b100 && c_dst == 3'b101)
        |=> (reg_s == '0)); // R2

    AST_BAD_DEST_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (c_op != 3'b000 && (c_dst == 3'b011 || c_dst == 3'b110 || c_dst == 3'b111))
        |=> ($stable(reg_a) && $stable(reg_b) && $stable(reg_r) &&
             $stable(reg_s) && $stable(reg_t))); // R8

    AST_AND_ZERO_SRC2: assert property (@(posedge clk) disable iff (rst)
        (c_op == 3'b010 && c_s2 == 3'b000 && c_dst == 3'b100) |=> (reg_r == '0)); // R6

    AST_REMOTE_WORD_COPY: assert property (@(posedge clk) disable iff (rst)
        (c_op == 3'b001 && c_s1 == 4'b0001 && c_s2 == 3'b000 && c_rd == 2'b01)
        |-> (rmt_we && !rmt_field && rmt_wr_data == imm_data)); // R10

endmodule

bind tca_exec tca_exec_chk #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W),
    .FIELD_W  (FIELD_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_word    (ctl_word),
    .imm_data    (imm_data),
    .carry_q     (carry_q),
    .reg_a       (reg_a),
    .reg_b       (reg_b),
    .reg_r       (reg_r),
    .reg_s       (reg_s),
    .reg_t       (reg_t),
    .rmt_we      (rmt_we),
    .rmt_field   (rmt_field),
    .rmt_wr_data (rmt_wr_data)
);

// File: tb/sim_tca_exec.sv
`timescale 1ns/1ps
module sim_tca_exec;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ctl_word = '0;
    logic [31:0] imm_data = '0;
    logic [31:0] rmt_rd_data = '0;
    logic        carry_q;
    logic [24:0] reg_a;
    logic [24:0] reg_b;
    logic [31:0] reg_r;
    logic [31:0] reg_s;
    logic [31:0] reg_t;
    logic        rmt_we;
    logic        rmt_field;
    logic [31:0] rmt_wr_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference state
    logic [24:0] m_a = '0;
    logic [24:0] m_b = '0;
    logic [31:0] m_r = '0;
    logic [31:0] m_s = '0;
    logic [31:0] m_t = '0;
    logic        m_c = 1'b0;

    always #2.5 clk = ~clk;

    tca_exec u0 (
        .clk         (clk),
        .rst         (rst),
        .ctl_word    (ctl_word),
        .imm_data    (imm_data),
        .rmt_rd_data (rmt_rd_data),
        .carry_q     (carry_q),
        .reg_a       (reg_a),
        .reg_b       (reg_b),
        .reg_r       (reg_r),
        .reg_s       (reg_s),
        .reg_t       (reg_t),
        .rmt_we      (rmt_we),
        .rmt_field   (rmt_field),
        .rmt_wr_data (rmt_wr_data)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [2:0] op, input logic [3:0] s1,
                                       input logic [2:0] s2, input logic d7,
                                       input logic [1:0] dsel, input logic [1:0] rd,
                                       input logic [7:0] sh);
        return {6'b0, op, s1, s2, sh, d7, 2'b00, rd, dsel, 1'b0};
    endfunction

    function automatic logic [31:0] ref_src(input logic [3:0] code, input logic [31:0] imm,
                                            input logic [31:0] rd);
        case (code)
            4'd0:    return 32'h0;
            4'd1:    return imm;
            4'd2:    return {m_a[23:0], 8'h00};
            4'd3:    return {m_b[23:0], 8'h00};
            4'd4:    return m_r;
            4'd5:    return m_s;
            4'd6:    return m_t;
            4'd7:    return 32'hFFFF_FFFF;
            4'd8:    return rd;
            4'd9:    return {23'b0, rd[8:0]};
            default: return 32'h0;
        endcase
    endfunction

    // returns {carry, result}
    function automatic logic [32:0] ref_alu(input logic [2:0] op, input logic [31:0] x,
                                            input logic [31:0] y, input logic c);
        logic [32:0] xx = {1'b0, x};
        logic [32:0] yy = {1'b0, y};
        logic [32:0] cc = {32'b0, c};
        case (op)
            3'b001:  return xx + yy;
            3'b011:  return xx + yy + cc;
            3'b101:  return xx - yy;
            3'b110:  return xx - yy - cc;
            3'b010:  return {c, x & y};
            3'b100:  return {c, x | y};
            3'b111:  return {c, x ^ y};
            default: return {c, 32'h0};
        endcase
    endfunction

    task automatic step(input string tag, input logic [31:0] ctl, input logic [31:0] imm,
                        input logic [31:0] rd);
        logic [2:0]  op;
        logic [31:0] x;
        logic [31:0] y;
        logic [32:0] cr;
        logic [31:0] res;
        logic        e_we;
        logic        e_fld;
        @(negedge clk);
        ctl_word    = ctl;
        imm_data    = imm;
        rmt_rd_data = rd;
        #1;
        op    = ctl[25:23];
        x     = ref_src(ctl[22:19], imm, rd);
        y     = ref_src({1'b0, ctl[18:16]}, imm, rd);
        cr    = ref_alu(op, x, y, m_c);
        res   = cr[31:0];
        e_we  = (op != 3'b000) && (ctl[4:3] == 2'b01 || ctl[4:3] == 2'b10);
        e_fld = (op != 3'b000) && (ctl[4:3] == 2'b10);
        chk(tag, "rmt_we", {31'b0, rmt_we}, {31'b0, e_we});
        if (e_we) begin
            chk(tag, "rmt_field", {31'b0, rmt_field}, {31'b0, e_fld});
            chk(tag, "rmt_wr_data", rmt_wr_data, e_fld ? {23'b0, res[8:0]} : res);
        end
        if (op != 3'b000) begin
            if (op == 3'b001 || op == 3'b011 || op == 3'b101 || op == 3'b110) m_c = cr[32];
            case ({ctl[7], ctl[2:1]})
                3'b000:  m_a = {1'b0, res[31:8]};
                3'b001:  m_b = {1'b0, res[31:8]};
                3'b010:  m_t = res;
                3'b100:  m_r = res;
                3'b101:  m_s = res;
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        chk(tag, "reg_a", {7'b0, reg_a}, {7'b0, m_a});
        chk(tag, "reg_b", {7'b0, reg_b}, {7'b0, m_b});
        chk(tag, "reg_r", reg_r, m_r);
        chk(tag, "reg_s", reg_s, m_s);
        chk(tag, "reg_t", reg_t, m_t);
        chk(tag, "carry", {31'b0, carry_q}, {31'b0, m_c});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rc;
        logic [31:0] ri;
        void'($urandom(32'h5EED_0C0A));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "reg_a", {7'b0, reg_a}, 32'h0);
        chk("R1", "reg_b", {7'b0, reg_b}, 32'h0);
        chk("R1", "reg_r", reg_r, 32'h0);
        chk("R1", "reg_s", reg_s, 32'h0);
        chk("R1", "reg_t", reg_t, 32'h0);
        chk("R1", "carry", {31'b0, carry_q}, 32'h0);
        chk("R1", "rmt_we", {31'b0, rmt_we}, 32'h0);

        // R5: immediate and constant sources
        step("R5", mk(3'b001, 4'd1, 3'd0, 1'b1, 2'b00, 2'b00, 8'h00), 32'h89AB_CDEF, 32'h0);
        step("R5", mk(3'b001, 4'd7, 3'd0, 1'b1, 2'b01, 2'b00, 8'h00), 32'h0, 32'h0);
        // R4: all-ones plus all-ones carries out
        step("R4", mk(3'b001, 4'd5, 3'd7, 1'b0, 2'b10, 2'b00, 8'h00), 32'h0, 32'h0);
        // R4: add with carry adds the set flag
        step("R4", mk(3'b011, 4'd0, 3'd0, 1'b1, 2'b00, 2'b00, 8'h00), 32'h0, 32'h0);
        // R4: subtract with borrow out
        step("R4", mk(3'b101, 4'd0, 3'd1, 1'b0, 2'b10, 2'b00, 8'h00), 32'h0000_0001, 32'h0);
        // R4: subtract with borrow-in set, equal operands still borrow
        step("R4", mk(3'b110, 4'd1, 3'd1, 1'b1, 2'b01, 2'b00, 8'h00), 32'h1234_5678, 32'h0);
        // R4: logic op keeps the flag
        step("R4", mk(3'b010, 4'd7, 3'd7, 1'b1, 2'b00, 2'b00, 8'h00), 32'h0, 32'h0);
        // R9: narrow destinations keep upper bits
        step("R9", mk(3'b001, 4'd1, 3'd0, 1'b0, 2'b00, 2'b00, 8'h00), 32'hDEAD_BEEF, 32'h0);
        step("R9", mk(3'b001, 4'd7, 3'd0, 1'b0, 2'b01, 2'b00, 8'h00), 32'h0, 32'h0);
        // R7: narrow sources aligned up, top bit dropped
        step("R7", mk(3'b001, 4'd2, 3'd0, 1'b1, 2'b00, 2'b00, 8'h00), 32'h0, 32'h0);
        step("R7", mk(3'b100, 4'd0, 3'd3, 1'b1, 2'b01, 2'b00, 8'h00), 32'h0, 32'h0);
        // R3: opcode zero writes nothing, even with destinations selected
        step("R3", mk(3'b000, 4'd7, 3'd7, 1'b1, 2'b00, 2'b01, 8'h00), 32'h0, 32'h0);
        step("R3", mk(3'b000, 4'd1, 3'd0, 1'b0, 2'b10, 2'b10, 8'h00), 32'hFFFF_FFFF, 32'h0);
        // R8: unlisted destination codes
        step("R8", mk(3'b001, 4'd1, 3'd0, 1'b0, 2'b11, 2'b00, 8'h00), 32'h5555_AAAA, 32'h0);
        step("R8", mk(3'b001, 4'd1, 3'd0, 1'b1, 2'b10, 2'b00, 8'h00), 32'h5555_AAAA, 32'h0);
        step("R8", mk(3'b001, 4'd1, 3'd0, 1'b1, 2'b11, 2'b00, 8'h00), 32'h5555_AAAA, 32'h0);
        // R10: remote field and word modes, reserved mode
        step("R10", mk(3'b001, 4'd1, 3'd0, 1'b1, 2'b11, 2'b10, 8'h00), 32'h1234_5FFF, 32'h0);
        step("R10", mk(3'b001, 4'd1, 3'd0, 1'b1, 2'b11, 2'b01, 8'h00), 32'hCAFE_F00D, 32'h0);
        step("R10", mk(3'b001, 4'd1, 3'd0, 1'b1, 2'b11, 2'b11, 8'h00), 32'hCAFE_F00D, 32'h0);
        // R11: register and remote destinations together
        step("R11", mk(3'b111, 4'd1, 3'd4, 1'b0, 2'b10, 2'b01, 8'h00), 32'h0F0F_0F0F, 32'h0);
        step("R11", mk(3'b001, 4'd1, 3'd0, 1'b0, 2'b00, 2'b10, 8'h00), 32'hABCD_E1FF, 32'h0);
        // R5: remote word, remote field and out-of-range codes
        step("R5", mk(3'b001, 4'd8, 3'd0, 1'b1, 2'b00, 2'b00, 8'h00), 32'h0, 32'hFFFF_FE55);
        step("R5", mk(3'b001, 4'd9, 3'd0, 1'b1, 2'b01, 2'b00, 8'h00), 32'h0, 32'hFFFF_FE55);
        step("R5", mk(3'b001, 4'd12, 3'd7, 1'b0, 2'b10, 2'b00, 8'h00), 32'h0, 32'hFFFF_FE55);
        // R6: every second-source code
        for (int k = 0; k < 8; k++) begin
            step("R6", mk(3'b001, 4'd0, 3'(k), 1'b1, 2'b00, 2'b00, 8'h00), 32'h7654_3210, 32'h0);
        end
        // R12: shift field ignored
        step("R12", mk(3'b101, 4'd4, 3'd1, 1'b0, 2'b10, 2'b01, 8'hFF), 32'h0000_1000, 32'h0);
        step("R12", mk(3'b001, 4'd5, 3'd6, 1'b1, 2'b01, 2'b10, 8'hA5), 32'h0, 32'h0);

        // R2: random control words over all operations
        for (int i = 0; i < 1500; i++) begin
            rc = $urandom;
            case ($urandom_range(3))
                0: ri = 32'h0;
                1: ri = 32'hFFFF_FFFF;
                2: ri = 32'h8000_0000;
                default: ri = $urandom;
            endcase
            step("R2", rc, ri, $urandom);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule